// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM's contents alive. It waits out the power-up pause and runs a burst of wake-up refresh cycles. After that it issues CAS-before-RAS (CBR) refresh cycles at an even rate that meets the 2K-row / 32 ms or 4K-row / 64 ms retention budget; a parameter selects the budget. The DRAM's internal row counter supplies the row, so the block drives no address and never moves data. Refreshes it cannot issue at once are owed, and a saturating count of them is kept.

The block shares the RAS and CAS strobes with an access sequencer through a request/grant pair. `ref_req` goes high whenever a refresh is owed or a wake-up cycle is pending, and it stays high until the current cycle has fully precharged. The sequencer raises `ref_gnt` once it has parked its own strobes high, and it holds the grant for as long as `ref_req` stays high. The block drives `ras_n` and `cas_n` only while it has the grant; an outer multiplexer selects the strobe source by the grant. `ready` tells the sequencer that normal access is allowed. `force_stop` tells it that the owed count is at its limit and that it must yield now. If the count would overflow, retention is no longer guaranteed, so the block flags an error and runs the wake-up burst again.

Top module: `cbr_refresh_sched`

## Requirements
- R1: During and straight after reset, `ras_n` and `cas_n` are high, and `ref_req`, `ready`, `force_stop` and `refresh_err` are low.
- R2: For PAUSE_US × CLK_MHZ clock cycles after reset (10000 at the defaults), `ref_req` stays low and both strobes stay high.
- R3: After the pause, exactly WAKE_CYCLES (8) refresh cycles are issued, and `ready` rises when the last of them completes.
- R4: Every refresh cycle is CBR-ordered. `cas_n` is low for at least T_CSR cycles before `ras_n` falls and stays low for at least T_CHR cycles after the fall. `ras_n` then stays low for exactly T_RAS cycles.
- R5: Between a rise of `ras_n` and its next fall, at least T_RP cycles pass with `ras_n` high.
- R6: Once ready, one refresh is owed every TICK = (window_us × CLK_MHZ) / rows cycles. The window is 32000 µs with 2048 rows, or 64000 µs with 4096 rows; both give 781 at 50 MHz. With the grant held high, successive `ras_n` falls are exactly TICK cycles apart.
- R7: A refresh cycle starts only when `ref_gnt` is high. While the strobes are driven low, `ref_req` is high. With the grant low, no strobe activity occurs.
- R8: Refreshes that cannot be issued are owed, up to OWED_MAX (8). When the grant returns, all owed refreshes are issued back to back, and `ref_req` falls once none is owed.
- R9: `force_stop` is high exactly while OWED_MAX refreshes are owed in the ready state.
- R10: If a refresh falls due while OWED_MAX are already owed, `refresh_err` pulses for one cycle and `ready` falls. The owed count is cleared, and WAKE_CYCLES refresh cycles run again without the power-up pause before `ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Sequencer has released the strobes to this block |
| ref_req | output | 1 | Block needs the strobes (owed or wake-up refresh, or a cycle in flight) |
| force_stop | output | 1 | Owed count at limit; sequencer must yield |
| ready | output | 1 | Initialisation complete; normal access allowed |
| refresh_err | output | 1 | One-cycle pulse: owed count overflowed, wake-up restarted |
| ras_n | output | 1 | Row strobe, active low, valid while granted |
| cas_n | output | 1 | Column strobe, active low, valid while granted |

## Verification
The refresh rate is tried first with the grant held high all the time, where the spacing of RAS falls must equal the tick period exactly. It is then tried with the grant withheld for three tick periods: the debt builds up, no strobe moves, and exactly three cycles come out back to back when the grant returns. This separates correct debt counting from a design that drops or merges deferred refreshes. A withholding of eight periods and then nine separates saturation (stop raised, still ready) from overflow (error pulse, ready lost, an eight-cycle re-wake with no pause). A strobe monitor checks every cycle of every pattern for CBR ordering, pulse width and precharge.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    CY_IDLE    = 2'd0,
    CY_SETUP   = 2'd1,
    CY_STROBE  = 2'd2,
    CY_RECOVER = 2'd3
  } cyc_t;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int TICK_CYCLES = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = $clog2(TICK_CYCLES + 1);
  localparam logic [W-1:0] LAST = W'(TICK_CYCLES - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int OWED_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  input  logic dec,
  output logic owed_any,
  output logic full,
  output logic overflow
);
  localparam int CW = $clog2(OWED_MAX + 1);
  localparam logic [CW-1:0] LIMIT = CW'(OWED_MAX);

  logic [CW-1:0] owed;

  assign full     = (owed == LIMIT);
  assign owed_any = (owed != '0);
  assign overflow = inc && !dec && full;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) owed <= '0;
    else if (inc && !dec && !full) owed <= owed + 1'b1;
    else if (dec && !inc && owed_any) owed <= owed - 1'b1;
  end
endmodule

// File: rtl/cbr_cycle_engine.sv
module cbr_cycle_engine
  import cbr_refresh_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_RAS = 4,
  parameter int T_RP  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);
  localparam int LONGEST = (T_RAS > T_RP) ? ((T_RAS > T_CSR) ? T_RAS : T_CSR)
                                          : ((T_RP > T_CSR) ? T_RP : T_CSR);
  localparam int CW = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] SETUP_LAST   = CW'(T_CSR - 1);
  localparam logic [CW-1:0] STROBE_LAST  = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RECOVER_LAST = CW'(T_RP - 1);
  localparam logic [CW-1:0] HOLD_LEN     = CW'(T_CHR);

  cyc_t          state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CY_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        CY_IDLE: if (start) begin
          state <= CY_SETUP;
          cnt   <= '0;
        end
        CY_SETUP: if (cnt == SETUP_LAST) begin
          state <= CY_STROBE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        CY_STROBE: if (cnt == STROBE_LAST) begin
          state <= CY_RECOVER;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        CY_RECOVER: if (cnt == RECOVER_LAST) begin
          state <= CY_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: begin
          state <= CY_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // CAS leads RAS low and is held a few cycles past the RAS fall.
  assign cas_n = !((state == CY_SETUP) || ((state == CY_STROBE) && (cnt < HOLD_LEN)));
  assign ras_n = !(state == CY_STROBE);
  assign busy  = (state != CY_IDLE);
  assign done  = (state == CY_RECOVER) && (cnt == RECOVER_LAST);
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_refresh_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter bit FOUR_K      = 1'b0,
  parameter int PAUSE_US    = 200,
  parameter int WAKE_CYCLES = 8,
  parameter int OWED_MAX    = 8,
  parameter int T_CSR       = 1,
  parameter int T_CHR       = 1,
  parameter int T_RAS       = 4,
  parameter int T_RP        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic force_stop,
  output logic ready,
  output logic refresh_err,
  output logic ras_n,
  output logic cas_n
);
  localparam int ROWS         = FOUR_K ? 4096 : 2048;
  localparam int WINDOW_US    = FOUR_K ? 64000 : 32000;
  localparam int TICK_CYCLES  = (WINDOW_US * CLK_MHZ) / ROWS;
  localparam int PAUSE_CYCLES = PAUSE_US * CLK_MHZ;
  localparam int PW           = $clog2(PAUSE_CYCLES + 1);
  localparam int WW           = $clog2(WAKE_CYCLES + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYCLES - 1);
  localparam logic [WW-1:0] WAKE_LAST  = WW'(WAKE_CYCLES - 1);

  phase_t        phase;
  logic [PW-1:0] pause_cnt;
  logic [WW-1:0] wake_cnt;

  logic tick, owed_any, owed_full, overflow;
  logic busy, done, start, want;

  refresh_interval_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (phase == PH_RUN),
    .tick (tick)
  );

  refresh_debt_counter #(.OWED_MAX(OWED_MAX)) u_debt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (phase != PH_RUN),
    .inc     (tick),
    .dec     (done && (phase == PH_RUN)),
    .owed_any(owed_any),
    .full    (owed_full),
    .overflow(overflow)
  );

  cbr_cycle_engine #(
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_engine (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .busy (busy),
    .done (done)
  );

  assign want    = (phase == PH_WAKE) || ((phase == PH_RUN) && owed_any);
  assign start   = want && ref_gnt && !busy;
  assign ref_req = want || busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_PAUSE;
      pause_cnt   <= '0;
      wake_cnt    <= '0;
      refresh_err <= 1'b0;
    end else begin
      refresh_err <= 1'b0;
      case (phase)
        PH_PAUSE: begin
          if (pause_cnt == PAUSE_LAST) begin
            phase    <= PH_WAKE;
            wake_cnt <= '0;
          end else pause_cnt <= pause_cnt + 1'b1;
        end
        PH_WAKE: begin
          if (done) begin
            if (wake_cnt == WAKE_LAST) phase <= PH_RUN;
            else wake_cnt <= wake_cnt + 1'b1;
          end
        end
        PH_RUN: begin
          if (overflow) begin
            phase       <= PH_WAKE;
            wake_cnt    <= '0;
            refresh_err <= 1'b1;
          end
        end
        default: phase <= PH_PAUSE;
      endcase
    end
  end

  assign ready      = (phase == PH_RUN);
  assign force_stop = (phase == PH_RUN) && owed_full;
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic ref_req,
  input logic force_stop,
  input logic ready,
  input logic refresh_err,
  input logic ras_n,
  input logic cas_n
);
  assert_cbr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_strobes_under_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> ref_req);

  assert_start_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |-> $past(ref_gnt));

  assert_stop_only_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_stop |-> ready);

  assert_err_drops_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_err |-> !ready);

  assert_err_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_err |=> !refresh_err);
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk u_chk (.*);

// File: tb/cbr_refresh_sched_test.sv
`timescale 1ns/1ps
module cbr_refresh_sched_test;
  localparam int TICK  = (32000 * 50) / 2048;
  localparam int PAUSE = 200 * 50;
  localparam int WAKE  = 8;
  localparam int CSR   = 1;
  localparam int CHR   = 1;
  localparam int RASW  = 4;
  localparam int RP    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b1;
  logic ref_req, force_stop, ready, refresh_err, ras_n, cas_n;

  always #10 clk = ~clk;

  cbr_refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .force_stop(force_stop), .ready(ready), .refresh_err(refresh_err),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int fall_count = 0;
  int last_fall = 0;
  int err_seen = 0;
  int viol_r4 = 0;
  int viol_r5 = 0;
  int cas_run = 0;
  int low_len = 0;
  int hold_len = 0;
  int high_len = 1000;
  logic ras_prev = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe monitor for R4 and R5, sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (refresh_err) err_seen++;
      if (ras_prev && !ras_n) begin
        fall_count++;
        last_fall = cyc;
        if (cas_run < CSR || cas_n) viol_r4++;
        if (high_len < RP) viol_r5++;
        low_len = 1;
        hold_len = cas_n ? 0 : 1;
      end else if (!ras_n) begin
        low_len++;
        if (!cas_n && hold_len == low_len - 1) hold_len++;
      end else if (!ras_prev && ras_n) begin
        if (low_len != RASW || hold_len < CHR) viol_r4++;
        high_len = 1;
      end else begin
        high_len++;
      end
      cas_run = (!cas_n && ras_n) ? cas_run + 1 : 0;
      ras_prev = ras_n;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fall();
    int n0 = fall_count;
    int guard = 0;
    while (fall_count == n0 && guard < 3 * TICK) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic test_reset_r1();
    rst_n = 1'b0;
    wait_cycles(4);
    chk(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
    chk(!ref_req && !ready, "R1 req/ready low in reset", {ref_req, ready}, 0);
    chk(!force_stop && !refresh_err, "R1 stop/err low in reset", {force_stop, refresh_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && !ref_req && !ready, "R1 state after release",
        {ras_n, cas_n, ref_req, ready}, 12);
  endtask

  task automatic test_pause_r2();
    int n = 1;
    int strobe_low = 0;
    while (!ref_req && n < PAUSE + 50) begin
      if (!ras_n || !cas_n) strobe_low++;
      @(negedge clk);
      n++;
    end
    chk(n >= PAUSE - 1 && n <= PAUSE + 2, "R2 pause length", n, PAUSE);
    chk(strobe_low == 0, "R2 strobes idle in pause", strobe_low, 0);
  endtask

  task automatic test_wake_r3();
    int n0 = fall_count;
    int guard = 0;
    while (!ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk(ready, "R3 ready after wake-up", ready, 1);
    chk(fall_count - n0 == WAKE, "R3 wake-up cycle count", fall_count - n0, WAKE);
  endtask

  task automatic test_rate_r6();
    int f1;
    wait_fall();
    f1 = last_fall;
    wait_fall();
    chk(last_fall - f1 == TICK, "R6 refresh spacing", last_fall - f1, TICK);
    wait_fall();
    chk(last_fall - f1 == 2 * TICK, "R6 refresh spacing second", last_fall - f1, 2 * TICK);
  endtask

  task automatic release_after_refresh();
    wait_fall();
    while (!ras_n) @(negedge clk);
    wait_cycles(RP + 3);
    ref_gnt = 1'b0;
  endtask

  task automatic test_postpone_r7_r8();
    int n0;
    release_after_refresh();
    n0 = fall_count;
    wait_cycles(3 * TICK);
    chk(fall_count == n0, "R7 no strobes without grant", fall_count - n0, 0);
    chk(ref_req && !force_stop, "R8 request held while owed", {ref_req, force_stop}, 2);
    ref_gnt = 1'b1;
    wait_cycles(80);
    chk(fall_count - n0 == 3, "R8 owed refreshes drained", fall_count - n0, 3);
    chk(!ref_req, "R8 request drops when nothing owed", ref_req, 0);
  endtask

  task automatic test_overflow_r9_r10();
    int n0;
    int t0;
    release_after_refresh();
    n0 = fall_count;
    wait_cycles(8 * TICK);
    chk(force_stop, "R9 stop at owed limit", force_stop, 1);
    chk(ready && err_seen == 0, "R9 still ready at limit", ready, 1);
    chk(fall_count == n0, "R7 no strobes while withheld", fall_count - n0, 0);
    wait_cycles(TICK);
    chk(err_seen == 1, "R10 one error pulse", err_seen, 1);
    chk(!ready && !force_stop, "R10 ready and stop drop", {ready, force_stop}, 0);
    chk(ref_req, "R10 re-wake requests strobes", ref_req, 1);
    n0 = fall_count;
    t0 = cyc;
    ref_gnt = 1'b1;
    while (!ready && cyc - t0 < 1000) @(negedge clk);
    chk(ready, "R10 ready after re-wake", ready, 1);
    chk(fall_count - n0 == WAKE, "R10 re-wake cycle count", fall_count - n0, WAKE);
    chk(cyc - t0 < 200, "R10 no pause on re-wake", cyc - t0, 200);
  endtask

  initial begin
    wait_cycles(1);
    test_reset_r1();
    test_pause_r2();
    test_wake_r3();
    test_rate_r6();
    test_postpone_r7_r8();
    test_overflow_r9_r10();
    test_rate_r6();
    chk(viol_r4 == 0, "R4 CBR ordering and pulse width", viol_r4, 0);
    chk(viol_r5 == 0, "R5 precharge between cycles", viol_r5, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule